// File: doc/BRIEF.md
# Four-Lane SD Data Block Receiver

This block takes the four data lines of an SD bus in wide mode, sampled once per bus clock, and turns each incoming data block into a stream of 32-bit words. A transfer is armed with a block count and a start pulse. For each block the receiver waits for the start bit, gathers the payload nibble by nibble and sends out a word after every eight nibbles. Each line has its own CRC16 generator. The receiver then captures the sixteen CRC bits the card sends on each line and compares them with the local values. When the programmed number of blocks has been received, it returns to idle.

The states are Idle, Hunt (waiting for the start bit), Payload, Crc (capturing the card's checksum) and End (consuming the end bit and scoring the block). The transitions are as follows:
- Idle to Hunt on an accepted start.
- Hunt to Payload when the start bit is seen and the output register is not blocked.
- Payload to Crc after the last payload nibble.
- Crc to End after the sixteenth checksum nibble.
- End to Hunt when more blocks remain, or End to Idle when the count is reached.
- Any busy state to Idle when the transfer timer expires.

Progress is reported as completed blocks, completed bytes and a count of blocks that failed their checksum. A transfer timer ends a transfer that takes too long.

Top module: `sd4_block_rx`

## Requirements
- R1: After reset the block is idle. `busy`, `out_valid`, `blocks_done`, `bytes_done`, `crc_err_count`, `crc_fail` and `timeout` are all zero.
- R2: A `start` pulse in Idle with `cfg_blocks` from 1 to MAX_BLOCKS begins a transfer of that many blocks. A start with `cfg_blocks` equal to 0 leaves the block idle. A start while busy changes nothing.
- R3: In Hunt, a clock on which all four lines are low is the start bit, and the first payload nibble is sampled on the next clock. While a word is held with `out_ready` low, the start bit is not taken and the block stays in Hunt.
- R4: Each output word holds eight consecutive nibbles. The first nibble is in bits 31:28 and the last is in bits 3:0. Bit n of a nibble comes from data line n. A block yields WORDS_PER_BLOCK words (128 by default, which is 512 bytes).
- R5: Each line has its own CRC16 with polynomial x^16+x^12+x^5+1. It is seeded to zero at the start bit and updated with that line's bit on every payload clock. The 16 clocks after the payload carry each line's received CRC, most significant bit first, followed by one end-bit clock.
- R6: A block in which any line's received CRC differs from the local value increments `crc_err_count` by one. `crc_fail` is high in Idle whenever `crc_err_count` is nonzero.
- R7: `blocks_done` counts completed blocks. `bytes_done` always equals `blocks_done` times 4×WORDS_PER_BLOCK.
- R8: After each block the receiver re-arms itself for the next block until the programmed count is reached, then returns to Idle. This holds for counts up to 256.
- R9: If a transfer is still busy TIMEOUT_CYCLES clocks after it starts, the block returns to Idle and raises `timeout`. The next accepted start clears the flag.
- R10: A word presented with `out_valid` stays valid and unchanged until `out_ready` is high on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a transfer when idle |
| cfg_blocks | input | 9 | Number of blocks in the transfer |
| sd_dat | input | 4 | Data lines; bit n is line n |
| out_data | output | 32 | Received word |
| out_valid | output | 1 | out_data holds a word |
| out_ready | input | 1 | Downstream takes the word |
| busy | output | 1 | Transfer in progress |
| blocks_done | output | 9 | Blocks completed |
| bytes_done | output | 18 | Bytes completed |
| crc_err_count | output | 9 | Blocks with a CRC mismatch |
| crc_fail | output | 1 | Idle with nonzero error count |
| timeout | output | 1 | Last transfer ended on the timer |

## Verification
The word-hold property assumes that, during a block, downstream takes each word before the next one is assembled, which is eight bus clocks later. The stimulus therefore keeps `out_ready` high during payload and lowers it only for the last word of a block, where the checksum and end clocks leave time. The hunt hold-off property assumes the lines stay low across the stall, just as a card would hold its start bit while the clock is stopped. The bench drives exactly that. Between blocks the lines idle high, so a zero nibble is never mistaken for a start bit.

// File: rtl/sd4rx_pkg.sv
package sd4rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_PAYLOAD,
        ST_CRC,
        ST_END
    } rx_state_t;

    localparam int          LANES    = 4;
    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;

endpackage

// File: rtl/sd4rx_crc_lane.sv
module sd4rx_crc_lane
    import sd4rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic cap,
    input  logic data_bit,
    output logic match
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] rx_q;
    logic             fb;

    assign fb = data_bit ^ crc_q[CRC_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
            rx_q  <= '0;
        end else begin
            if (clear) begin
                crc_q <= '0;
                rx_q  <= '0;
            end else begin
                if (step) crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
                if (cap)  rx_q  <= {rx_q[CRC_W-2:0], data_bit};
            end
        end
    end

    assign match = (crc_q == rx_q);

    // R5: seeding at the start bit
    a_r5_seed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> crc_q == '0);

    // R5: generator only moves on payload clocks
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !step) |=> $stable(crc_q));

endmodule

// File: rtl/sd4rx_packer.sv
module sd4rx_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nib_en,
    input  logic [3:0]  nib,
    input  logic        emit,
    input  logic        ready,
    output logic [31:0] data,
    output logic        valid
);

    logic [27:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            if (nib_en) sh_q <= {sh_q[23:0], nib};
            if (emit) begin
                data  <= {sh_q, nib};
                valid <= 1'b1;
            end else if (valid && ready) begin
                valid <= 1'b0;
            end
        end
    end

    // R10: a held word is neither dropped nor altered
    a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data)));

    // R4: every completed nibble group is presented
    a_r4_emit_shows: assert property (@(posedge clk) disable iff (!rst_n)
        emit |=> valid);

endmodule

// File: rtl/sd4_block_rx.sv
module sd4_block_rx
    import sd4rx_pkg::*;
#(
    parameter  int WORDS_PER_BLOCK = 128,
    parameter  int MAX_BLOCKS      = 256,
    parameter  int TIMEOUT_CYCLES  = 2_000_000,
    localparam int CNT_W           = $clog2(MAX_BLOCKS + 1),
    localparam int BYTE_W          = $clog2(MAX_BLOCKS * WORDS_PER_BLOCK * 4 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cfg_blocks,
    input  logic [3:0]        sd_dat,
    output logic [31:0]       out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              busy,
    output logic [CNT_W-1:0]  blocks_done,
    output logic [BYTE_W-1:0] bytes_done,
    output logic [CNT_W-1:0]  crc_err_count,
    output logic              crc_fail,
    output logic              timeout
);

    localparam int NIBS      = WORDS_PER_BLOCK * 8;
    localparam int NIB_W     = $clog2(NIBS);
    localparam int PC_W      = (NIB_W > 4) ? NIB_W : 4;
    localparam int BLK_BYTES = WORDS_PER_BLOCK * 4;
    localparam int TO_W      = $clog2(TIMEOUT_CYCLES + 1);

    rx_state_t          state_q, state_d;
    logic [PC_W-1:0]    pos_q;
    logic [CNT_W-1:0]   target_q, blocks_q, errs_q;
    logic [BYTE_W-1:0]  bytes_q;
    logic [TO_W-1:0]    tcnt_q;
    logic               tout_q;
    logic               launch, stall, sof, expire;
    logic               last_pay, last_crc, last_blk;
    logic               pay_en, crc_en, emit;
    logic [LANES-1:0]   lane_ok;

    assign launch   = (state_q == ST_IDLE) && start && (cfg_blocks != '0)
                      && (cfg_blocks <= CNT_W'(MAX_BLOCKS));
    assign stall    = out_valid && !out_ready;
    assign sof      = (state_q == ST_HUNT) && (sd_dat == 4'h0) && !stall;
    assign expire   = (state_q != ST_IDLE) && (tcnt_q == TO_W'(TIMEOUT_CYCLES - 1));
    assign last_pay = (pos_q == PC_W'(NIBS - 1));
    assign last_crc = (pos_q == PC_W'(CRC_W - 1));
    assign last_blk = ((blocks_q + CNT_W'(1)) == target_q);
    assign pay_en   = (state_q == ST_PAYLOAD);
    assign crc_en   = (state_q == ST_CRC);
    assign emit     = pay_en && (pos_q[2:0] == 3'd7);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (launch)   state_d = ST_HUNT;
            ST_HUNT:    if (sof)      state_d = ST_PAYLOAD;
            ST_PAYLOAD: if (last_pay) state_d = ST_CRC;
            ST_CRC:     if (last_crc) state_d = ST_END;
            ST_END:     state_d = last_blk ? ST_IDLE : ST_HUNT;
            default:    state_d = ST_IDLE;
        endcase
        if (expire) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q    <= '0;
            target_q <= '0;
            blocks_q <= '0;
            errs_q   <= '0;
            bytes_q  <= '0;
            tcnt_q   <= '0;
            tout_q   <= 1'b0;
        end else begin
            if (launch) begin
                target_q <= cfg_blocks;
                blocks_q <= '0;
                bytes_q  <= '0;
                errs_q   <= '0;
                tout_q   <= 1'b0;
                tcnt_q   <= '0;
            end else if (state_q != ST_IDLE) begin
                tcnt_q <= tcnt_q + TO_W'(1);
                if (expire) tout_q <= 1'b1;
            end

            unique case (state_q)
                ST_PAYLOAD: pos_q <= last_pay ? '0 : pos_q + PC_W'(1);
                ST_CRC:     pos_q <= pos_q + PC_W'(1);
                default:    pos_q <= '0;
            endcase

            if ((state_q == ST_END) && !expire) begin
                blocks_q <= blocks_q + CNT_W'(1);
                bytes_q  <= bytes_q + BYTE_W'(BLK_BYTES);
                if (lane_ok != '1) errs_q <= errs_q + CNT_W'(1);
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sd4rx_crc_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (sof),
            .step     (pay_en),
            .cap      (crc_en),
            .data_bit (sd_dat[l]),
            .match    (lane_ok[l])
        );
    end

    sd4rx_packer u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .nib_en (pay_en),
        .nib    (sd_dat),
        .emit   (emit),
        .ready  (out_ready),
        .data   (out_data),
        .valid  (out_valid)
    );

    assign busy          = (state_q != ST_IDLE);
    assign blocks_done   = blocks_q;
    assign bytes_done    = bytes_q;
    assign crc_err_count = errs_q;
    assign crc_fail      = (state_q == ST_IDLE) && (errs_q != '0);
    assign timeout       = tout_q;

    a_r7_below_target: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (blocks_q < target_q));

    a_r7_bytes_track: assert property (@(posedge clk) disable iff (!rst_n)
        bytes_q == BYTE_W'(blocks_q) * BYTE_W'(BLK_BYTES));

    a_r6_errs_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        errs_q <= blocks_q);

    a_r9_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tout_q |-> (state_q == ST_IDLE));

    a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HUNT) && stall && !expire) |=> (state_q == ST_HUNT));

    a_r2_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && start && (cfg_blocks == '0)) |=> (state_q == ST_IDLE));

endmodule

// File: tb/sd4_block_rx_bench.sv
module sd4_block_rx_bench;

    localparam int W    = 4;
    localparam int MAXB = 256;
    localparam int TO   = 20000;
    localparam int BB   = W * 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [8:0]  cfg_blocks;
    logic [3:0]  sd_dat;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_ready;
    logic        busy;
    logic [8:0]  blocks_done;
    logic [17:0] bytes_done;
    logic [8:0]  crc_err_count;
    logic        crc_fail;
    logic        timeout;

    int n_chk  = 0;
    int n_fail = 0;
    int got_n  = 0;
    bit finished = 0;
    logic [31:0] got [0:1023];
    logic [31:0] expw [0:1023];

    always #5 clk = ~clk;

    sd4_block_rx #(.WORDS_PER_BLOCK(W), .MAX_BLOCKS(MAXB), .TIMEOUT_CYCLES(TO)) u_sd4_block_rx (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_blocks(cfg_blocks),
        .sd_dat(sd_dat), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .busy(busy), .blocks_done(blocks_done),
        .bytes_done(bytes_done), .crc_err_count(crc_err_count),
        .crc_fail(crc_fail), .timeout(timeout)
    );

    always @(negedge clk) begin
        if (out_valid && out_ready) begin
            if (got_n < 1024) got[got_n] = out_data;
            got_n++;
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic put(input logic [3:0] v);
        sd_dat = v;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] gen_word(input int mode, input int b, input int j);
        case (mode)
            0:       return 32'h0;
            1:       return 32'hFFFF_FFFF;
            2:       return (32'h0102_0304 * 32'(j + 1)) + 32'(b);
            default: return (32'(j) * 32'h9E37_79B9) ^ (32'(b) << 16) ^ 32'hA5A5_0F0F;
        endcase
    endfunction

    function automatic logic [15:0] lane_crc(input int mode, input int b, input int l);
        logic [15:0] c = 16'h0;
        for (int j = 0; j < W; j++) begin
            logic [31:0] w = gen_word(mode, b, j);
            for (int k = 0; k < 8; k++) begin
                logic bt = w[28 - 4 * k + l];
                logic fb = bt ^ c[15];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    task automatic send_block(input int b, input int mode, input logic [3:0] bad,
                              input bit no_start, input bit drop_last);
        logic [15:0] c [4];
        for (int l = 0; l < 4; l++) c[l] = lane_crc(mode, b, l);
        if (!no_start) begin
            put(4'hF);
            put(4'hF);
            put(4'h0);
        end
        for (int j = 0; j < W; j++) begin
            logic [31:0] w = gen_word(mode, b, j);
            expw[b * W + j] = w;
            for (int k = 0; k < 8; k++) begin
                if (drop_last && j == W - 1 && k == 7) out_ready = 1'b0;
                put(w[31 - 4 * k -: 4]);
            end
        end
        for (int i = 0; i < 16; i++) begin
            logic [3:0] n = {c[3][15 - i], c[2][15 - i], c[1][15 - i], c[0][15 - i]};
            if (i == 0) n = n ^ bad;
            put(n);
        end
        put(4'hF);
    endtask

    task automatic check_words(input int n);
        check("R4 word count", 32'(got_n), 32'(n));
        for (int i = 0; i < n && i < 1024; i++) check("R4 word value", got[i], expw[i]);
    endtask

    task automatic run(input int nblk, input int mode, input int badblk, input logic [3:0] bad);
        int e;
        got_n = 0;
        cfg_blocks = 9'(nblk);
        start = 1'b1;
        put(4'hF);
        start = 1'b0;
        for (int b = 0; b < nblk; b++)
            send_block(b, mode, (b == badblk) ? bad : 4'h0, 1'b0, 1'b0);
        repeat (3) put(4'hF);
        e = (badblk >= 0 && badblk < nblk && bad != 4'h0) ? 1 : 0;
        check("R8 idle after count", 32'(busy), 32'd0);
        check("R7 blocks_done", 32'(blocks_done), 32'(nblk));
        check("R7 bytes_done", 32'(bytes_done), 32'(nblk * BB));
        check("R5 R6 error count", 32'(crc_err_count), 32'(e));
        check("R6 crc_fail", 32'(crc_fail), 32'(e));
        check("R9 timeout clear", 32'(timeout), 32'd0);
        check_words(nblk * W);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; cfg_blocks = '0; sd_dat = 4'hF; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        put(4'hF);
        check("R1 busy", 32'(busy), 0);
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 blocks_done", 32'(blocks_done), 0);
        check("R1 bytes_done", 32'(bytes_done), 0);
        check("R1 err", 32'(crc_err_count), 0);
        check("R1 crc_fail", 32'(crc_fail), 0);
        check("R1 timeout", 32'(timeout), 0);

        // R2: zero count is not a transfer
        cfg_blocks = 9'd0; start = 1'b1; put(4'hF); start = 1'b0;
        put(4'hF);
        check("R2 zero count ignored", 32'(busy), 0);

        // R4 R5 R8: sweep block counts and data patterns
        for (int n = 1; n <= 3; n++)
            for (int m = 0; m < 4; m++) run(n, m, -1, 4'h0);

        // R5 R6: a bad checksum on each lane in turn
        for (int l = 0; l < 4; l++) run(2, 3, 1, 4'(1 << l));
        run(3, 2, 0, 4'hF);

        // R2: start while busy changes nothing
        got_n = 0;
        cfg_blocks = 9'd1; start = 1'b1; put(4'hF);
        cfg_blocks = 9'd3; put(4'hF); start = 1'b0;
        send_block(0, 2, 4'h0, 1'b0, 1'b0);
        repeat (3) put(4'hF);
        check("R2 busy start ignored idle", 32'(busy), 0);
        check("R2 busy start ignored count", 32'(blocks_done), 1);

        // R3 R10: stall at the start bit while the last word waits
        got_n = 0;
        cfg_blocks = 9'd2; start = 1'b1; put(4'hF); start = 1'b0;
        send_block(0, 3, 4'h0, 1'b0, 1'b1);
        put(4'hF); put(4'hF);
        repeat (5) put(4'h0);
        check("R3 held in hunt", 32'(busy), 1);
        check("R3 no block advance", 32'(blocks_done), 1);
        check("R10 word held", 32'(out_valid), 1);
        check("R10 word value", out_data, gen_word(3, 0, W - 1));
        check("R10 nothing taken", 32'(got_n), 32'(W - 1));
        out_ready = 1'b1;
        put(4'h0);
        send_block(1, 3, 4'h0, 1'b1, 1'b0);
        repeat (3) put(4'hF);
        check("R3 second block done", 32'(blocks_done), 2);
        check("R3 idle", 32'(busy), 0);
        check("R3 no crc error", 32'(crc_err_count), 0);
        check_words(2 * W);

        // R8: largest count
        run(256, 2, -1, 4'h0);

        // R9: timer expiry
        cfg_blocks = 9'd2; start = 1'b1; put(4'hF); start = 1'b0;
        send_block(0, 1, 4'h0, 1'b0, 1'b0);
        repeat (TO - 400) put(4'hF);
        check("R9 still busy before limit", 32'(busy), 1);
        check("R9 no flag before limit", 32'(timeout), 0);
        repeat (600) put(4'hF);
        check("R9 flag after limit", 32'(timeout), 1);
        check("R9 idle after limit", 32'(busy), 0);
        check("R9 partial blocks", 32'(blocks_done), 1);
        run(1, 0, -1, 4'h0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule